// File: doc/BRIEF.md
# Polled Byte-Stream Port for a Two-Wire Slave

This block is an I2C-compatible slave that lets a bus master pull an outgoing byte stream out of a transmit FIFO by polling. It also lets the master deliver message bytes into a receive FIFO. The slave never starts a transfer and never sends and receives in the same transfer. SCL and SDA enter as sampled inputs. The slave pulls SDA low through a drive-low enable.

The master sees 256 read-only byte registers:

| Address | Content |
|---|---|
| 0x00 to 0xFC | Constant zero |
| 0xFD | High byte of the pending-byte count |
| 0xFE | Low byte of the pending-byte count |
| 0xFF | The stream: each read pops the transmit FIFO, or returns 0xFF when the FIFO is empty |

An internal pointer advances after each byte read and stops at 0xFF, so a burst that starts low ends up draining the stream. A write transfer is interpreted by its length:
- A write of exactly one data byte loads the pointer. This is the first half of a random read.
- A write of two or more data bytes is message data, and every byte goes to the receive FIFO.

The slave's 7-bit address is 0x42 unless a configuration input supplies another value. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_stream_port`

## Requirements
- R1: While reset is held, the SDA drive enable, the FIFO pop and the FIFO push are all low. After reset the pointer sits at 0xFF, so a read with no preceding pointer load returns stream bytes.
- R2: The slave acknowledges (drives SDA low in the ninth clock) only an address byte whose upper 7 bits equal its address. Its address is 0x42 when the configuration-valid input is low, and the configuration address when that input is high. After any other address, SDA stays released and the FIFOs are not touched until the next start.
- R3: Reading any register from 0x00 to 0xFC returns 0x00.
- R4: Register 0xFD returns bits 15:8 and register 0xFE returns bits 7:0 of the transmit FIFO level. The level is captured when a read address is acknowledged and held for the whole transfer.
- R5: Each byte read at 0xFF while the transmit FIFO is non-empty returns the FIFO head and issues exactly one single-cycle pop.
- R6: Each byte read at 0xFF while the transmit FIFO is empty returns 0xFF and issues no pop.
- R7: The pointer increments by one after every byte read and saturates at 0xFF, so a burst that starts below 0xFD continues into the count registers and then the stream.
- R8: A write transfer with exactly one data byte, ended by a stop or a repeated start, loads that byte into the pointer and pushes nothing.
- R9: A write transfer with N ≥ 2 data bytes pushes all N bytes, in bus order, one per push pulse, and leaves the pointer unchanged. Every data byte is acknowledged.
- R10: When the master answers a byte with NACK, the slave releases SDA and fetches and pops nothing more in that transfer.
- R11: SDA drive changes only while the synchronized SCL is low. Pop and push never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| cfg_addr_valid_i | input | 1 | High selects cfg_addr_i as the slave address |
| cfg_addr_i | input | 7 | Configured slave address |
| tx_level_i | input | LVL_W | Bytes held in the transmit FIFO |
| tx_data_i | input | 8 | Transmit FIFO head byte |
| tx_pop_o | output | 1 | Single-cycle pop of the transmit FIFO |
| rx_push_o | output | 1 | Single-cycle push into the receive FIFO |
| rx_data_o | output | 8 | Byte pushed with rx_push_o |

## Verification
The checker watches these rules on every cycle:
- SDA drive moves only while SCL is low.
- Pops and pushes are single-cycle pulses, are never simultaneous, and never hit an empty FIFO.
- The captured count does not move during a read.
- The pointer never goes backwards during a read.

The values returned for each register class, the 0xFF padding, the length rule that tells a pointer load from message data, the address match and the configuration override can only be shown by the bench's transfers. The bench compares those against its own model of the FIFO and the pointer.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;

    localparam int BYTE_BITS = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_BITS + 1);
    localparam int CNT_W     = 16;

    localparam logic [7:0] REG_CNT_HI = 8'hFD;
    localparam logic [7:0] REG_CNT_LO = 8'hFE;
    localparam logic [7:0] REG_STREAM = 8'hFF;
    localparam logic [7:0] PAD_BYTE   = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } eng_state_e;

    typedef struct packed {
        eng_state_e           st;
        logic [BIT_CNT_W-1:0] bit_cnt;
        logic [7:0]           shreg;
        logic                 rw;
        logic                 nack;
        logic [7:0]           ptr;
        logic [CNT_W-1:0]     cnt;
        logic [7:0]           held;
        logic [1:0]           nwr;
        logic                 sda_oe;
        logic                 pop;
        logic                 push;
        logic [7:0]           push_data;
    } eng_regs_t;

    localparam eng_regs_t ENG_RST = '{
        st:        ST_IDLE,
        bit_cnt:   '0,
        shreg:     '0,
        rw:        1'b0,
        nack:      1'b0,
        ptr:       REG_STREAM,
        cnt:       '0,
        held:      '0,
        nwr:       '0,
        sda_oe:    1'b0,
        pop:       1'b0,
        push:      1'b0,
        push_data: '0
    };

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sync_q, sda_sync_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sync_q[STAGES-1];
            sda_prev_q <= sda_sync_q[STAGES-1];
        end
    end

    assign scl_o      = scl_sync_q[STAGES-1];
    assign sda_o      = sda_sync_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    // SDA edges while SCL stays high mark the frame boundaries
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/i2c_read_map.sv
module i2c_read_map
    import i2c_stream_pkg::*;
(
    input  logic [7:0]       ptr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             stream_avail_i,
    input  logic [7:0]       stream_byte_i,
    output logic [7:0]       data_o,
    output logic             pop_o
);
    always_comb begin
        data_o = 8'h00;
        pop_o  = 1'b0;
        unique case (ptr_i)
            REG_CNT_HI: data_o = cnt_i[CNT_W-1 -: 8];
            REG_CNT_LO: data_o = cnt_i[7:0];
            REG_STREAM: begin
                data_o = stream_avail_i ? stream_byte_i : PAD_BYTE;
                pop_o  = stream_avail_i;
            end
            default:    data_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
    import i2c_stream_pkg::*;
#(
    parameter int LVL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             sda_i,
    input  logic [6:0]       dev_addr_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [7:0]       rd_byte_i,
    input  logic             rd_pop_i,
    output logic [7:0]       ptr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             in_read_o,
    output logic             sda_oe_o,
    output logic             tx_pop_o,
    output logic             rx_push_o,
    output logic [7:0]       rx_data_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_BITS);

    eng_regs_t d, q;

    function automatic logic [7:0] ptr_step(input logic [7:0] p);
        return (p == REG_STREAM) ? REG_STREAM : p + 8'd1;
    endfunction

    always_comb begin
        d      = q;
        d.pop  = 1'b0;
        d.push = 1'b0;
        if (start_i || stop_i) begin
            // close an open write: one byte loads the pointer, more flush
            if (q.st == ST_WR || q.st == ST_WR_ACK) begin
                if (q.nwr == 2'd1) begin
                    d.ptr = q.held;
                end else if (q.nwr == 2'd2) begin
                    d.push      = 1'b1;
                    d.push_data = q.held;
                end
            end
            d.sda_oe  = 1'b0;
            d.nwr     = '0;
            d.bit_cnt = '0;
            d.st      = start_i ? ST_ADDR : ST_IDLE;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        d.shreg   = {q.shreg[6:0], sda_i};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall_i && q.bit_cnt == LAST_BIT) begin
                        d.bit_cnt = '0;
                        if (q.shreg[7:1] == dev_addr_i) begin
                            d.st     = ST_ADDR_ACK;
                            d.sda_oe = 1'b1;
                            d.rw     = q.shreg[0];
                            d.cnt    = CNT_W'(tx_level_i);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        if (q.rw) begin
                            d.shreg   = rd_byte_i;
                            d.pop     = rd_pop_i;
                            d.ptr     = ptr_step(q.ptr);
                            d.sda_oe  = ~rd_byte_i[7];
                            d.bit_cnt = BIT_CNT_W'(1);
                            d.st      = ST_RD;
                        end else begin
                            d.sda_oe  = 1'b0;
                            d.bit_cnt = '0;
                            d.st      = ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise_i) begin
                        d.shreg   = {q.shreg[6:0], sda_i};
                        d.bit_cnt = q.bit_cnt + 1'b1;
                    end else if (scl_fall_i && q.bit_cnt == LAST_BIT) begin
                        d.sda_oe  = 1'b1;
                        d.bit_cnt = '0;
                        d.st      = ST_WR_ACK;
                        if (q.nwr != 2'd0) begin
                            d.push      = 1'b1;
                            d.push_data = q.held;
                        end
                        d.held = q.shreg;
                        d.nwr  = (q.nwr == 2'd0) ? 2'd1 : 2'd2;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        d.sda_oe = 1'b0;
                        d.st     = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_fall_i) begin
                        if (q.bit_cnt == LAST_BIT) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_RD_ACK;
                        end else begin
                            d.sda_oe  = ~q.shreg[6];
                            d.shreg   = {q.shreg[6:0], 1'b0};
                            d.bit_cnt = q.bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise_i) begin
                        d.nack = sda_i;
                    end else if (scl_fall_i) begin
                        if (!q.nack) begin
                            d.shreg   = rd_byte_i;
                            d.pop     = rd_pop_i;
                            d.ptr     = ptr_step(q.ptr);
                            d.sda_oe  = ~rd_byte_i[7];
                            d.bit_cnt = BIT_CNT_W'(1);
                            d.st      = ST_RD;
                        end else begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ENG_RST;
        else        q <= d;
    end

    assign ptr_o     = q.ptr;
    assign cnt_o     = q.cnt;
    assign in_read_o = (q.st == ST_RD) || (q.st == ST_RD_ACK);
    assign sda_oe_o  = q.sda_oe;
    assign tx_pop_o  = q.pop;
    assign rx_push_o = q.push;
    assign rx_data_o = q.push_data;

endmodule

// File: rtl/i2c_stream_port.sv
module i2c_stream_port
    import i2c_stream_pkg::*;
#(
    parameter int         LVL_W       = 12,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEF_ADDR    = 7'h42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             cfg_addr_valid_i,
    input  logic [6:0]       cfg_addr_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [7:0]       tx_data_i,
    output logic             tx_pop_o,
    output logic             rx_push_o,
    output logic [7:0]       rx_data_o
);
    logic             scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [6:0]       dev_addr;
    logic             stream_avail;
    logic [7:0]       ptr_q, rd_byte;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_pop, in_read;

    assign dev_addr     = cfg_addr_valid_i ? cfg_addr_i : DEF_ADDR;
    assign stream_avail = |tx_level_i;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    i2c_read_map u_map (
        .ptr_i          (ptr_q),
        .cnt_i          (cnt_q),
        .stream_avail_i (stream_avail),
        .stream_byte_i  (tx_data_i),
        .data_o         (rd_byte),
        .pop_o          (rd_pop)
    );

    i2c_slave_engine #(.LVL_W(LVL_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (bus_start),
        .stop_i     (bus_stop),
        .sda_i      (sda_s),
        .dev_addr_i (dev_addr),
        .tx_level_i (tx_level_i),
        .rd_byte_i  (rd_byte),
        .rd_pop_i   (rd_pop),
        .ptr_o      (ptr_q),
        .cnt_o      (cnt_q),
        .in_read_o  (in_read),
        .sda_oe_o   (sda_oe_o),
        .tx_pop_o   (tx_pop_o),
        .rx_push_o  (rx_push_o),
        .rx_data_o  (rx_data_o)
    );

endmodule

// File: rtl/i2c_stream_port_chk.sv
module i2c_stream_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        scl_lvl,
    input logic        tx_pop,
    input logic        tx_avail,
    input logic        rx_push,
    input logic        in_read,
    input logic [15:0] cnt,
    input logic [7:0]  ptr
);
    // R11
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R11
    pop_push_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pop && rx_push));

    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_avail);

    // R5
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !tx_pop);

    // R9
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read)) |-> $stable(cnt));

    // R7
    ptr_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && $past(in_read)) |-> (ptr >= $past(ptr)));

endmodule

bind i2c_stream_port i2c_stream_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe_o),
    .scl_lvl  (scl_s),
    .tx_pop   (tx_pop_o),
    .tx_avail (stream_avail),
    .rx_push  (rx_push_o),
    .in_read  (in_read),
    .cnt      (cnt_q),
    .ptr      (ptr_q)
);

// File: tb/tb_i2c_stream_port.sv
module tb_i2c_stream_port;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W      = 12;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_bus, sda_oe;
    logic cfg_valid = 1'b0;
    logic [6:0] cfg_addr = 7'h00;
    logic [LVL_W-1:0] tx_level;
    logic [7:0] tx_data, rx_data;
    logic tx_pop, rx_push;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0] fifo_mem [0:511];
    int wrp = 0;
    int rdp = 0;
    logic [7:0] rx_log [0:1023];
    int rxn = 0;

    assign tx_level = LVL_W'(wrp - rdp);
    assign tx_data  = fifo_mem[rdp[8:0]];
    assign sda_bus  = sda_m & ~sda_oe;

    always @(posedge clk) begin
        if (tx_pop) rdp <= rdp + 1;
        if (rx_push) begin
            rx_log[rxn[9:0]] <= rx_data;
            rxn <= rxn + 1;
        end
    end

    i2c_stream_port #(.LVL_W(LVL_W)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .scl_i            (scl_m),
        .sda_i            (sda_bus),
        .sda_oe_o         (sda_oe),
        .cfg_addr_valid_i (cfg_valid),
        .cfg_addr_i       (cfg_addr),
        .tx_level_i       (tx_level),
        .tx_data_i        (tx_data),
        .tx_pop_o         (tx_pop),
        .rx_push_o        (rx_push),
        .rx_data_o        (rx_data)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [6:0] dev = 7'h42;
    logic [7:0] exp_ptr = 8'hFF;
    int exp_head = 0;
    logic [7:0] first_rd;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        b = sda_bus;  tick(Q - Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        acked = !a;
    endtask

    task automatic rbyte(output logic [7:0] v, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(!give_ack);
    endtask

    task automatic push_stream(input logic [7:0] v);
        fifo_mem[wrp[8:0]] = v;
        wrp = wrp + 1;
    endtask

    function automatic logic [7:0] step(input logic [7:0] p);
        return (p == 8'hFF) ? 8'hFF : p + 8'd1;
    endfunction

    task automatic rd_txn(input bit set_ptr, input logic [7:0] a, input int n);
        bit ok;
        logic [7:0] v, e;
        int cap;
        string tg;
        bus_start();
        if (set_ptr) begin
            wbyte({dev, 1'b0}, ok); chk(ok, "R2 addr-ack", ok, 1);
            wbyte(a, ok);           chk(ok, "R8 ptr-byte-ack", ok, 1);
            bus_start();
            exp_ptr = a;
        end
        wbyte({dev, 1'b1}, ok); chk(ok, "R2 read-ack", ok, 1);
        cap = wrp - exp_head;
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            if (exp_ptr < 8'hFD) begin
                tg = "R3"; e = 8'h00;
            end else if (exp_ptr == 8'hFD) begin
                tg = "R4"; e = cap[15:8];
            end else if (exp_ptr == 8'hFE) begin
                tg = "R4"; e = cap[7:0];
            end else if (wrp > exp_head) begin
                tg = "R5"; e = fifo_mem[exp_head[8:0]]; exp_head++;
            end else begin
                tg = "R6"; e = 8'hFF;
            end
            if (i > 0) tg = {tg, " R7"};
            if (i == 0) first_rd = v;
            chk(v == e, tg, v, e);
            exp_ptr = step(exp_ptr);
        end
        bus_stop();
        tick(8);
        chk(rdp == exp_head, "R10 pop-total", rdp, exp_head);
        chk(sda_oe == 1'b0, "R10 released", sda_oe, 0);
    endtask

    task automatic wr_txn(input int n);
        bit ok;
        logic [7:0] wd [0:7];
        int base;
        base = rxn;
        for (int i = 0; i < n; i++) wd[i] = 8'($urandom);
        bus_start();
        wbyte({dev, 1'b0}, ok); chk(ok, "R2 wr-addr-ack", ok, 1);
        for (int i = 0; i < n; i++) begin
            wbyte(wd[i], ok);
            chk(ok, "R9 data-ack", ok, 1);
        end
        bus_stop();
        tick(8);
        if (n == 1) begin
            exp_ptr = wd[0];
            chk(rxn == base, "R8 no-push", rxn - base, 0);
        end else begin
            chk(rxn == base + n, "R9 push-count", rxn - base, n);
            for (int i = 0; i < n; i++)
                chk(rx_log[(base + i) % 1024] == wd[i], "R9 order",
                    rx_log[(base + i) % 1024], wd[i]);
        end
    endtask

    task automatic foreign_read(input logic [6:0] other);
        bit ok;
        int r0, x0;
        r0 = rdp; x0 = rxn;
        bus_start();
        wbyte({other, 1'b1}, ok);
        chk(!ok, "R2 foreign-nack", ok, 0);
        bus_stop();
        tick(8);
        chk(rdp == r0 && rxn == x0, "R2 untouched", rdp - r0, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(5);
        // R1 quiet outputs in reset
        chk(sda_oe == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0, "R1 reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);
        for (int i = 0; i < 3; i++) push_stream(8'hA0 + 8'(i));
        rd_txn(1'b0, 8'h00, 2);
        chk(first_rd == 8'hA0, "R1 ptr-at-stream", first_rd, 8'hA0);

        // counts above 255 and a burst running into the stream: R4 R7
        for (int i = 0; i < 300; i++) push_stream(8'($urandom));
        rd_txn(1'b1, 8'hFB, 7);
        rd_txn(1'b1, 8'h05, 1);

        // drain then pad: R6
        rd_txn(1'b1, 8'hFF, (wrp - exp_head) + 3);

        // address handling: R2
        foreign_read(7'h17);
        cfg_addr = 7'h17; cfg_valid = 1'b1; dev = 7'h17;
        push_stream(8'h5C);
        rd_txn(1'b0, 8'h00, 1);
        foreign_read(7'h42);
        cfg_valid = 1'b0; dev = 7'h42;

        // one-byte write loads the pointer: R8
        wr_txn(1);
        rd_txn(1'b0, 8'h00, 3);
        bus_start();
        begin
            bit ok;
            wbyte({dev, 1'b0}, ok);
            wbyte(8'hFD, ok);
        end
        bus_stop();
        tick(8);
        exp_ptr = 8'hFD;
        rd_txn(1'b0, 8'h00, 2);

        // message writes leave pointer alone: R9
        wr_txn(4);
        wr_txn(2);
        rd_txn(1'b0, 8'h00, 1);

        for (int it = 0; it < 40; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            case (op)
                0: if (wrp - exp_head < 400)
                       for (int k = 0; k < int'($urandom_range(1, 20)); k++)
                           push_stream(8'($urandom));
                1: rd_txn(1'b1, ($urandom_range(0, 1) == 1) ? 8'($urandom_range(248, 255))
                                                           : 8'($urandom),
                          int'($urandom_range(1, 6)));
                2: rd_txn(1'b0, 8'h00, int'($urandom_range(1, 6)));
                default: wr_txn(int'($urandom_range(1, 5)));
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule